// File: doc/BRIEF.md
# Masked Template Squared-Error Correlator

This block scores one stored image chip against one reference template at a grid of shifted placements. For each placement it walks the whole template square. At each template pixel whose mask bit is set, it takes the absolute difference between the chip pixel and the template pixel, squares it and adds it to a running total. Pixels whose mask bit is clear are skipped. The total for a placement is emitted as one score. The score carries the class and pose labels given at launch and the placement offset.

The chip and the template sit in two internal RAMs that the surrounding logic fills through plain write ports before a sweep. The template RAM holds a mask bit next to each pixel. A start pulse launches a sweep. In coarse mode the sweep covers an 11 by 11 grid of offsets, and in fine mode it covers a 7 by 7 grid around a supplied centre offset. The block streams one score per placement with no gaps between placements, and it raises a done pulse after the last score. Choosing which templates to run, ranking the scores and enhancing the image all happen outside the block.

Top module: `tsc_correlator`

## Requirements
- R1: Pixels are 8-bit unsigned. Let B = (CHIP_DIM - TPL_DIM) / 2. With the template at offset (x, y), template pixel (r, c) is compared with chip pixel at row B + y + r and column B + x + c. Chip address = row * CHIP_DIM + column, and template address = r * TPL_DIM + c. The score is the sum of (chip - template)^2 over the contributing pixels.
- R2: A template pixel whose mask bit is 0 adds nothing to any score, whatever the pixel values. A template with every mask bit at 0 scores 0 at every offset.
- R3: With fine_mode = 0 (coarse), one sweep emits 121 scores. y runs from -5 to +5 in the outer loop and x runs from -5 to +5 in the inner loop, both ascending. The centre inputs are ignored.
- R4: With fine_mode = 1, one sweep emits 49 scores at offsets centre + d, where d runs from -3 to +3 on each axis, in the same order as R3. Each centre component must lie in -5..+5.
- R5: Every score carries the class and pose sampled at start, together with its absolute x and y offsets as signed values.
- R6: Each placement's total starts from zero. No part of the previous placement's total carries over, even when that placement's first template pixel is masked out.
- R7: Let N = TPL_DIM^2. If start is sampled at rising edge 0, score k is presented after edge N + 2 + k*N. score_valid is high for exactly one cycle per score.
- R8: done is high for exactly one cycle, in the cycle right after the final score of a sweep.
- R9: The score is 32 bits wide. A placement in which every pixel is valid and differs by 255 yields exactly N * 65025.
- R10: A start pulse that arrives while a sweep is still running is ignored. It changes neither the labels, nor the mode, nor the number of scores, nor the number of done pulses.
- R11: During and right after a synchronous reset, score_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_we | input | 1 | Chip RAM write enable |
| chip_waddr | input | 13 | Chip RAM write address (row * CHIP_DIM + column) |
| chip_wdata | input | 8 | Chip pixel to write |
| tpl_we | input | 1 | Template RAM write enable |
| tpl_waddr | input | 10 | Template RAM write address (row * TPL_DIM + column) |
| tpl_wdata | input | 8 | Template pixel to write |
| tpl_wmask | input | 1 | Mask bit stored with the template pixel (1 = contributes) |
| start | input | 1 | Launch a sweep; ignored while one is running |
| fine_mode | input | 1 | 0 = coarse 11x11 grid, 1 = fine 7x7 grid around the centre |
| class_id | input | 5 | Class label, latched at start |
| pose_id | input | 7 | Pose label, latched at start |
| centre_x | input | 5 | Signed fine-mode centre, x |
| centre_y | input | 5 | Signed fine-mode centre, y |
| score_valid | output | 1 | One-cycle strobe for a score |
| score | output | 32 | Accumulated masked squared error |
| score_class | output | 5 | Class tag of the score |
| score_pose | output | 7 | Pose tag of the score |
| score_off_x | output | 5 | Signed x offset of the score |
| score_off_y | output | 5 | Signed y offset of the score |
| done | output | 1 | One-cycle pulse after the last score |

## Verification
The address walk reads the RAMs at the first edge after a pixel is addressed. The squared error is registered at the second edge, and the total goes into the output register at the third edge. So score k of a sweep is due after edge TPL_DIM^2 + 2 + k*TPL_DIM^2, counted from the edge that samples start, and done is due one edge after the last score. The bench records the start edge with its own cycle counter and samples outputs on falling edges. It logs the cycle at which each strobe appears and compares that cycle with the formula above, so it checks both the value and the exact timing of every score and of the done pulse.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int PIX_W  = 8;
  localparam int ACC_W  = 32;
  localparam int CLS_W  = 5;
  localparam int POSE_W = 7;
  localparam int OFF_W  = 5;

  typedef logic signed [OFF_W-1:0] off_t;

  // sideband that travels with each template pixel down the pipeline
  typedef struct packed {
    logic              valid;
    logic              first;      // first pixel of a placement
    logic              last;       // last pixel of a placement
    logic              final_pos;  // last pixel of the whole sweep
    logic [CLS_W-1:0]  cls;
    logic [POSE_W-1:0] pose;
    off_t              off_x;
    off_t              off_y;
  } tag_t;
endpackage

// File: rtl/tsc_ram.sv
module tsc_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tsc_sweep.sv
module tsc_sweep import tsc_pkg::*; #(
  parameter int CHIP_DIM = 79,
  parameter int TPL_DIM  = 32,
  parameter int COARSE_R = 5,
  parameter int FINE_R   = 3,
  localparam int BASE    = (CHIP_DIM - TPL_DIM) / 2,
  localparam int T_CW    = $clog2(TPL_DIM),
  localparam int CHIP_AW = $clog2(CHIP_DIM * CHIP_DIM),
  localparam int TPL_AW  = $clog2(TPL_DIM * TPL_DIM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              fine_i,
  input  logic [CLS_W-1:0]  cls_i,
  input  logic [POSE_W-1:0] pose_i,
  input  off_t              cx_i,
  input  off_t              cy_i,
  output logic              run_o,
  output tag_t              tag_o,
  output logic [CHIP_AW-1:0] chip_raddr_o,
  output logic [TPL_AW-1:0]  tpl_raddr_o
);
  logic              run_q;
  logic [T_CW-1:0]   pc_q, pr_q;
  off_t              dx_q, dy_q, cx_q, cy_q, rad_q;
  logic [CLS_W-1:0]  cls_q;
  logic [POSE_W-1:0] pose_q;

  logic col_end, row_end, x_end, y_end;
  off_t ox, oy;
  int   row_i, col_i;

  assign col_end = (pc_q == T_CW'(TPL_DIM - 1));
  assign row_end = (pr_q == T_CW'(TPL_DIM - 1));
  assign x_end   = (dx_q == rad_q);
  assign y_end   = (dy_q == rad_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      pc_q   <= '0;
      pr_q   <= '0;
      dx_q   <= '0;
      dy_q   <= '0;
      cx_q   <= '0;
      cy_q   <= '0;
      rad_q  <= '0;
      cls_q  <= '0;
      pose_q <= '0;
    end else if (start_i && !run_q) begin
      run_q  <= 1'b1;
      pc_q   <= '0;
      pr_q   <= '0;
      rad_q  <= fine_i ? off_t'(FINE_R) : off_t'(COARSE_R);
      dx_q   <= fine_i ? -off_t'(FINE_R) : -off_t'(COARSE_R);
      dy_q   <= fine_i ? -off_t'(FINE_R) : -off_t'(COARSE_R);
      cx_q   <= fine_i ? cx_i : '0;
      cy_q   <= fine_i ? cy_i : '0;
      cls_q  <= cls_i;
      pose_q <= pose_i;
    end else if (run_q) begin
      if (!col_end) begin
        pc_q <= pc_q + T_CW'(1);
      end else begin
        pc_q <= '0;
        if (!row_end) begin
          pr_q <= pr_q + T_CW'(1);
        end else begin
          pr_q <= '0;
          if (!x_end) begin
            dx_q <= dx_q + off_t'(1);
          end else begin
            dx_q <= -rad_q;
            if (y_end) run_q <= 1'b0;
            else       dy_q  <= dy_q + off_t'(1);
          end
        end
      end
    end
  end

  always_comb begin
    ox    = cx_q + dx_q;
    oy    = cy_q + dy_q;
    row_i = BASE + int'(oy) + int'(pr_q);
    col_i = BASE + int'(ox) + int'(pc_q);
    chip_raddr_o = CHIP_AW'(row_i * CHIP_DIM + col_i);
    tpl_raddr_o  = TPL_AW'(int'(pr_q) * TPL_DIM + int'(pc_q));

    tag_o.valid     = run_q;
    tag_o.first     = (pc_q == '0) && (pr_q == '0);
    tag_o.last      = col_end && row_end;
    tag_o.final_pos = col_end && row_end && x_end && y_end;
    tag_o.cls       = cls_q;
    tag_o.pose      = pose_q;
    tag_o.off_x     = ox;
    tag_o.off_y     = oy;
  end

  assign run_o = run_q;
endmodule

// File: rtl/tsc_accum.sv
module tsc_accum import tsc_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  tag_t              tag_a,    // aligned with the RAM read address
  input  logic [PIX_W-1:0]  chip_q,   // RAM data, one edge later
  input  logic [PIX_W:0]    tpl_q,    // {mask, pixel}
  output logic              valid_o,
  output logic [ACC_W-1:0]  score_o,
  output logic [CLS_W-1:0]  cls_o,
  output logic [POSE_W-1:0] pose_o,
  output off_t              off_x_o,
  output off_t              off_y_o,
  output logic              done_o
);
  tag_t               t1, t2;
  logic               mask2;
  logic [2*PIX_W-1:0] sq2;
  logic [ACC_W-1:0]   acc_q, contrib, sum;
  logic [PIX_W-1:0]   ad;
  logic               last_sweep_q;

  always_comb begin
    ad      = (chip_q >= tpl_q[PIX_W-1:0]) ? chip_q - tpl_q[PIX_W-1:0]
                                           : tpl_q[PIX_W-1:0] - chip_q;
    contrib = mask2 ? ACC_W'(sq2) : '0;
    sum     = (t2.first ? '0 : acc_q) + contrib;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t1           <= '0;
      t2           <= '0;
      mask2        <= 1'b0;
      sq2          <= '0;
      acc_q        <= '0;
      valid_o      <= 1'b0;
      score_o      <= '0;
      cls_o        <= '0;
      pose_o       <= '0;
      off_x_o      <= '0;
      off_y_o      <= '0;
      last_sweep_q <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      t1    <= tag_a;
      t2    <= t1;
      mask2 <= tpl_q[PIX_W];
      sq2   <= (2*PIX_W)'(ad) * (2*PIX_W)'(ad);
      if (t2.valid) acc_q <= sum;
      valid_o <= t2.valid && t2.last;
      if (t2.valid && t2.last) begin
        score_o <= sum;
        cls_o   <= t2.cls;
        pose_o  <= t2.pose;
        off_x_o <= t2.off_x;
        off_y_o <= t2.off_y;
      end
      last_sweep_q <= t2.valid && t2.final_pos;
      done_o       <= last_sweep_q;
    end
  end
endmodule

// File: rtl/tsc_correlator.sv
module tsc_correlator import tsc_pkg::*; #(
  parameter int CHIP_DIM = 79,
  parameter int TPL_DIM  = 32,
  parameter int COARSE_R = 5,
  parameter int FINE_R   = 3,
  localparam int CHIP_AW = $clog2(CHIP_DIM * CHIP_DIM),
  localparam int TPL_AW  = $clog2(TPL_DIM * TPL_DIM)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     chip_we,
  input  logic [CHIP_AW-1:0]       chip_waddr,
  input  logic [PIX_W-1:0]         chip_wdata,
  input  logic                     tpl_we,
  input  logic [TPL_AW-1:0]        tpl_waddr,
  input  logic [PIX_W-1:0]         tpl_wdata,
  input  logic                     tpl_wmask,
  input  logic                     start,
  input  logic                     fine_mode,
  input  logic [CLS_W-1:0]         class_id,
  input  logic [POSE_W-1:0]        pose_id,
  input  logic signed [OFF_W-1:0]  centre_x,
  input  logic signed [OFF_W-1:0]  centre_y,
  output logic                     score_valid,
  output logic [ACC_W-1:0]         score,
  output logic [CLS_W-1:0]         score_class,
  output logic [POSE_W-1:0]        score_pose,
  output logic signed [OFF_W-1:0]  score_off_x,
  output logic signed [OFF_W-1:0]  score_off_y,
  output logic                     done
);
  generate
    if (CHIP_DIM - TPL_DIM < 2 * (COARSE_R + FINE_R)) begin : g_bad_geom
      $error("template does not fit the chip at every offset");
    end
    if (COARSE_R + FINE_R > 15 || TPL_DIM < 2) begin : g_bad_range
      $error("offset range or template size out of bounds");
    end
  endgenerate

  tag_t                tag_a;
  logic                run;
  logic [CHIP_AW-1:0]  chip_raddr;
  logic [TPL_AW-1:0]   tpl_raddr;
  logic [PIX_W-1:0]    chip_q;
  logic [PIX_W:0]      tpl_q;

  tsc_sweep #(
    .CHIP_DIM (CHIP_DIM),
    .TPL_DIM  (TPL_DIM),
    .COARSE_R (COARSE_R),
    .FINE_R   (FINE_R)
  ) u_sweep (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start),
    .fine_i       (fine_mode),
    .cls_i        (class_id),
    .pose_i       (pose_id),
    .cx_i         (centre_x),
    .cy_i         (centre_y),
    .run_o        (run),
    .tag_o        (tag_a),
    .chip_raddr_o (chip_raddr),
    .tpl_raddr_o  (tpl_raddr)
  );

  tsc_ram #(.DEPTH(CHIP_DIM * CHIP_DIM), .WIDTH(PIX_W)) u_chip_ram (
    .clk   (clk),
    .we    (chip_we),
    .waddr (chip_waddr),
    .wdata (chip_wdata),
    .raddr (chip_raddr),
    .rdata (chip_q)
  );

  tsc_ram #(.DEPTH(TPL_DIM * TPL_DIM), .WIDTH(PIX_W + 1)) u_tpl_ram (
    .clk   (clk),
    .we    (tpl_we),
    .waddr (tpl_waddr),
    .wdata ({tpl_wmask, tpl_wdata}),
    .raddr (tpl_raddr),
    .rdata (tpl_q)
  );

  tsc_accum u_accum (
    .clk     (clk),
    .rst     (rst),
    .tag_a   (tag_a),
    .chip_q  (chip_q),
    .tpl_q   (tpl_q),
    .valid_o (score_valid),
    .score_o (score),
    .cls_o   (score_class),
    .pose_o  (score_pose),
    .off_x_o (score_off_x),
    .off_y_o (score_off_y),
    .done_o  (done)
  );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker import tsc_pkg::*; #(
  parameter int TPL_DIM  = 32,
  parameter int COARSE_R = 5,
  parameter int FINE_R   = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    run,
  input logic [CLS_W-1:0]        held_cls,
  input logic                    score_valid,
  input logic [ACC_W-1:0]        score,
  input logic signed [OFF_W-1:0] score_off_x,
  input logic signed [OFF_W-1:0] score_off_y,
  input logic                    done
);
  localparam logic [ACC_W-1:0] MAX_SCORE = ACC_W'(TPL_DIM * TPL_DIM * 65025);
  localparam int               LIM       = COARSE_R + FINE_R;

  // R7: each score strobe lasts one cycle
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
    score_valid |=> !score_valid);

  // R8: done comes right after a score and is a single-cycle pulse
  a_r8_done_after_score: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(score_valid));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: a total never exceeds every pixel at full difference
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    score_valid |-> score <= MAX_SCORE);

  // R4: offsets stay inside the reachable window
  a_r4_offset_window: assert property (@(posedge clk) disable iff (rst)
    score_valid |-> (int'(score_off_x) >= -LIM && int'(score_off_x) <= LIM &&
                     int'(score_off_y) >= -LIM && int'(score_off_y) <= LIM));

  // R10: a start during a sweep leaves the held labels alone
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (run && start) |=> $stable(held_cls));

  // R11: nothing is strobed in the cycle after reset
  a_r11_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!score_valid && !done));
endmodule

bind tsc_correlator tsc_checker #(
  .TPL_DIM  (TPL_DIM),
  .COARSE_R (COARSE_R),
  .FINE_R   (FINE_R)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .run         (run),
  .held_cls    (tag_a.cls),
  .score_valid (score_valid),
  .score       (score),
  .score_off_x (score_off_x),
  .score_off_y (score_off_y),
  .done        (done)
);

// File: tb/tsc_correlator_tb.sv
`timescale 1ns/1ps
module tsc_correlator_tb;
  localparam int CD   = 24;
  localparam int TD   = 4;
  localparam int N    = TD * TD;
  localparam int BASE = (CD - TD) / 2;
  localparam int CAW  = $clog2(CD * CD);
  localparam int TAW  = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic                chip_we = 1'b0;
  logic [CAW-1:0]      chip_waddr = '0;
  logic [7:0]          chip_wdata = '0;
  logic                tpl_we = 1'b0;
  logic [TAW-1:0]      tpl_waddr = '0;
  logic [7:0]          tpl_wdata = '0;
  logic                tpl_wmask = 1'b0;
  logic                start = 1'b0;
  logic                fine_mode = 1'b0;
  logic [4:0]          class_id = '0;
  logic [6:0]          pose_id = '0;
  logic signed [4:0]   centre_x = '0;
  logic signed [4:0]   centre_y = '0;
  logic                score_valid;
  logic [31:0]         score;
  logic [4:0]          score_class;
  logic [6:0]          score_pose;
  logic signed [4:0]   score_off_x;
  logic signed [4:0]   score_off_y;
  logic                done;

  tsc_correlator #(.CHIP_DIM(CD), .TPL_DIM(TD), .COARSE_R(5), .FINE_R(3)) u_dut (
    .clk(clk), .rst(rst),
    .chip_we(chip_we), .chip_waddr(chip_waddr), .chip_wdata(chip_wdata),
    .tpl_we(tpl_we), .tpl_waddr(tpl_waddr), .tpl_wdata(tpl_wdata), .tpl_wmask(tpl_wmask),
    .start(start), .fine_mode(fine_mode), .class_id(class_id), .pose_id(pose_id),
    .centre_x(centre_x), .centre_y(centre_y),
    .score_valid(score_valid), .score(score), .score_class(score_class),
    .score_pose(score_pose), .score_off_x(score_off_x), .score_off_y(score_off_y),
    .done(done)
  );

  int unsigned chip_m [CD*CD];
  int unsigned tpl_m  [N];
  bit          mask_m [N];

  int nchk = 0, nfail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // falling-edge monitor
  int nv = 0, nd = 0, done_cyc = 0;
  longint got_sc [200];
  int got_x [200], got_y [200], got_c [200], got_p [200], got_cyc [200];
  always @(negedge clk) begin
    if (!rst && score_valid && nv < 200) begin
      got_sc[nv] = score;  got_x[nv] = int'(score_off_x); got_y[nv] = int'(score_off_y);
      got_c[nv] = score_class; got_p[nv] = score_pose; got_cyc[nv] = cyc;
      nv++;
    end
    if (!rst && done) begin nd++; done_cyc = cyc; end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R7 watchdog: actual %0d cycles expected completion", cyc);
    finish_run();
  end

  task automatic load_all();
    for (int a = 0; a < CD*CD; a++) begin
      @(negedge clk); chip_we = 1'b1; chip_waddr = CAW'(a); chip_wdata = 8'(chip_m[a]);
    end
    @(negedge clk); chip_we = 1'b0;
    for (int a = 0; a < N; a++) begin
      @(negedge clk); tpl_we = 1'b1; tpl_waddr = TAW'(a);
      tpl_wdata = 8'(tpl_m[a]); tpl_wmask = mask_m[a];
    end
    @(negedge clk); tpl_we = 1'b0;
  endtask

  function automatic longint exp_score(int ox, int oy);
    longint s = 0;
    for (int r = 0; r < TD; r++)
      for (int c = 0; c < TD; c++)
        if (mask_m[r*TD+c]) begin
          int d = int'(chip_m[(BASE+oy+r)*CD + BASE+ox+c]) - int'(tpl_m[r*TD+c]);
          s += longint'(d * d);
        end
    return s;
  endfunction

  task automatic sweep(bit fine, int cx, int cy, int cls, int pose, bit poke, string sreq);
    int rad, side, npos, s;
    rad = fine ? 3 : 5; side = 2*rad + 1; npos = side * side;
    nv = 0; nd = 0;
    @(negedge clk);
    start = 1'b1; fine_mode = fine; centre_x = 5'(cx); centre_y = 5'(cy);
    class_id = 5'(cls); pose_id = 7'(pose); s = cyc;
    @(negedge clk); start = 1'b0;
    if (poke) begin  // R10: restart attempt mid-sweep with other settings
      repeat (5*N) @(negedge clk);
      start = 1'b1; fine_mode = !fine; class_id = 5'(cls ^ 1); pose_id = 7'(pose + 1);
      centre_x = 5'(0); centre_y = 5'(0);
      @(negedge clk); start = 1'b0;
    end
    for (int w = 0; w < npos*N + 40 && nd == 0; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(nv == npos, fine ? "R4" : "R3", "score count", nv, npos);
    for (int k = 0; k < npos && k < nv; k++) begin
      int ex, ey;
      ex = (fine ? cx : 0) - rad + k % side;
      ey = (fine ? cy : 0) - rad + k / side;
      check(got_x[k] == ex, fine ? "R4" : "R3", "x offset", got_x[k], ex);
      check(got_y[k] == ey, fine ? "R4" : "R3", "y offset", got_y[k], ey);
      check(got_c[k] == cls && got_p[k] == pose, poke ? "R10" : "R5", "class/pose",
            got_c[k]*128 + got_p[k], cls*128 + pose);
      check(got_sc[k] == exp_score(ex, ey), sreq, "score", got_sc[k], exp_score(ex, ey));
      check(got_cyc[k] == s + 3 + N + k*N, "R7", "score cycle", got_cyc[k], s + 3 + N + k*N);
    end
    check(nd == 1, poke ? "R10" : "R8", "done pulses", nd, 1);
    check(done_cyc == s + 4 + npos*N, "R8", "done cycle", done_cyc, s + 4 + npos*N);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs quiet in reset
    check(score_valid == 1'b0 && done == 1'b0, "R11", "outputs in reset", score_valid + 2*done, 0);
    rst = 1'b0;
    @(negedge clk);
    check(score_valid == 1'b0 && done == 1'b0, "R11", "outputs after reset", score_valid + 2*done, 0);

    // R1/R6: random data, mask with first pixel cleared so each total must restart at zero
    for (int a = 0; a < CD*CD; a++) chip_m[a] = $urandom_range(255);
    for (int a = 0; a < N; a++) begin tpl_m[a] = $urandom_range(255); mask_m[a] = (a % 3) != 0; end
    load_all();
    sweep(1'b0, 0, 0, 3, 17, 1'b0, "R1/R6");
    sweep(1'b1, 2, -3, 19, 100, 1'b0, "R1");
    // R10: mid-sweep start ignored, corner centre
    sweep(1'b1, -5, 5, 7, 44, 1'b1, "R1");

    // R2: masked-out pixels with extreme values, then an all-clear mask
    for (int a = 0; a < N; a++) begin
      mask_m[a] = (a % 2) == 0; tpl_m[a] = mask_m[a] ? $urandom_range(255) : 255;
    end
    for (int a = 0; a < CD*CD; a++) chip_m[a] = (a % 5 == 0) ? 0 : $urandom_range(255);
    load_all();
    sweep(1'b1, 1, 1, 2, 5, 1'b0, "R2");
    for (int a = 0; a < N; a++) mask_m[a] = 1'b0;
    load_all();
    sweep(1'b0, 0, 0, 30, 127, 1'b0, "R2");

    // R9: full-scale difference on every pixel
    for (int a = 0; a < CD*CD; a++) chip_m[a] = 255;
    for (int a = 0; a < N; a++) begin tpl_m[a] = 0; mask_m[a] = 1'b1; end
    load_all();
    sweep(1'b1, 0, 0, 1, 1, 1'b0, "R9");
    check(got_sc[0] == longint'(N) * 65025, "R9", "full-scale score", got_sc[0], longint'(N) * 65025);

    finish_run();
  end
endmodule